// File: doc/BRIEF.md
# Clock Update Cycle Controller

This block paces the once-per-second advance of a calendar clock. It runs directly on the 32.768 kHz timebase and keeps a phase counter that spans one second. It gives the time counters a single-cycle advance strobe. Before each advance it raises an update-in-progress flag for a short fixed window. Software polls that flag to know when the time registers are about to change.

The controller takes two inputs from the control registers. The first is a three-bit divider-select field, which can run the divider, hold it in reset or freeze it. The second is a stop bit that lets software rewrite the time without an update interfering. A register-file write indication is also wired in. The design guarantees that this indication has no influence on the update window, so rewriting alarm or time registers can never leave the flag stuck. All pins are plain control and status wires. There is no data stream and so no back-pressure.

When the divider is released from reset, the first advance lands exactly half a second later. Advances then follow every full second.

Top module: `update_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low, `uip`, `upd_start` and `upd_end` are 0. After reset is released with `div_sel` = 3'b010, the phase behaves as if the divider had just left reset (see R3).
- R2: A `div_sel` value with its two upper bits both set (3'b110 or 3'b111) holds the divider in reset. While it is held, `uip`, `upd_start` and `upd_end` stay 0, and the phase is re-armed to the half-second point.
- R3: On the first clock edge that samples `div_sel` = 3'b010, after a hold or after reset, counting of running edges begins. `upd_end` pulses after running edge number TICKS_PER_SEC/2.
- R4: `uip` is 1 for exactly HOLD_TICKS consecutive cycles immediately before each `upd_end` pulse. `upd_start` pulses for one cycle in the first of those cycles.
- R5: `upd_end` is a one-cycle pulse that appears in the same cycle in which `uip` falls.
- R6: After the first advance, further `upd_end` pulses follow every TICKS_PER_SEC cycles, as long as running conditions persist.
- R7: While `set_stop` is 1, `uip`, `upd_start` and `upd_end` are 0. The first `upd_end` after `set_stop` returns to 0 comes after running edge number TICKS_PER_SEC, counted from the first edge that samples `set_stop` = 0.
- R8: Any other `div_sel` value (neither 3'b010 nor 3'b11x) freezes the phase. While frozen, `uip` and both pulses are 0. On return to 3'b010, counting resumes from the frozen phase.
- R9: `regfile_wr` has no effect. Toggling it, including during the `uip` window, changes neither the window length nor the timing of any pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase (one tick per cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 3 | Divider-select field: 3'b010 runs, 3'b11x holds in reset, any other value freezes |
| set_stop | input | 1 | Suppresses updates so software can write the time |
| regfile_wr | input | 1 | Register-file write indication; must not affect timing |
| upd_start | output | 1 | One-cycle pulse at the start of the update window |
| upd_end | output | 1 | One-cycle advance strobe to the time counters |
| uip | output | 1 | Update-in-progress status flag |

## Verification
The assertions assume that `set_stop` and `div_sel` do not change in the exact cycle where a registered pulse is already committed. A pulse that is already registered would otherwise appear once after the stop takes effect. The stimulus changes these inputs only at falling edges and only at phases well away from any update window. The window-length and no-cancel checks assume HOLD_TICKS is smaller than half of TICKS_PER_SEC. The bench keeps this with 64 ticks per second and a window of 8. The bench toggles `regfile_wr` on every cycle across two complete windows, so the write-independence claims are exercised at every phase of the window.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_HALT = 2'd2
  } div_mode_e;

  localparam logic [2:0] DIV_CODE_RUN = 3'b010;

  // Upper two bits set: divider held in reset; run code: count; else frozen.
  function automatic div_mode_e decode_div(input logic [2:0] code);
    if (code[2:1] == 2'b11)        return MODE_HOLD;
    else if (code == DIV_CODE_RUN) return MODE_RUN;
    else                           return MODE_HALT;
  endfunction

endpackage

// File: rtl/ucc_div_decode.sv
module ucc_div_decode
  import ucc_pkg::*;
(
  input  logic [2:0] div_sel,
  output div_mode_e  mode,
  output logic       running
);

  always_comb begin
    mode    = decode_div(div_sel);
    running = (mode == MODE_RUN);
  end

endmodule

// File: rtl/ucc_phase_counter.sv
module ucc_phase_counter
  import ucc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int CW            = $clog2(TICKS_PER_SEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  div_mode_e     mode,
  input  logic          set_stop,
  output logic [CW-1:0] phase
);

  localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  // Phase wraps LAST -> 0 at each advance; a hold re-arms to the half point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= HALF;
    end else begin
      unique case (mode)
        MODE_HOLD: phase <= HALF;
        MODE_RUN: begin
          if (set_stop)           phase <= '0;
          else if (phase == LAST) phase <= '0;
          else                    phase <= phase + 1'b1;
        end
        default: phase <= phase;
      endcase
    end
  end

  AST_HOLD_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> (phase == HALF)); // R2
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALT) |=> $stable(phase)); // R8
  AST_SET_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && set_stop) |=> (phase == '0)); // R7

endmodule

// File: rtl/ucc_window_gen.sv
module ucc_window_gen #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int HOLD_TICKS    = 8,
  parameter int CW            = $clog2(TICKS_PER_SEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic          set_stop,
  input  logic          regfile_wr,
  input  logic [CW-1:0] phase,
  output logic          uip,
  output logic          upd_start,
  output logic          upd_end
);

  localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] WIN_FIRST = CW'(TICKS_PER_SEC - HOLD_TICKS);
  localparam logic [CW-1:0] PRE_WIN   = CW'(TICKS_PER_SEC - HOLD_TICKS - 1);
  localparam int            LW        = $clog2(HOLD_TICKS + 1);

  logic active;
  logic start_q, end_q;

  assign active = running && !set_stop;

  // Window is purely a function of phase: no other event can extend it.
  assign uip = active && (phase >= WIN_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      start_q <= active && (phase == PRE_WIN);
      end_q   <= active && (phase == LAST);
    end
  end

  assign upd_start = start_q;
  assign upd_end   = end_q;

  // Length of the current run of uip cycles, for the boundedness check.
  logic [LW-1:0] win_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 win_len <= '0;
    else if (!uip)                              win_len <= '0;
    else if (win_len != LW'(HOLD_TICKS))        win_len <= win_len + 1'b1;
  end

  AST_UIP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    uip |-> (win_len < LW'(HOLD_TICKS))); // R4
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!running || set_stop) |-> !uip); // R7
  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_start && running && !set_stop) |-> uip); // R4
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |=> !upd_end); // R5
  AST_END_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (uip && phase == LAST) |=> (upd_end && !uip)); // R5
  AST_WR_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (uip && regfile_wr && phase != LAST) |=> (uip || set_stop || !running)); // R9

endmodule

// File: rtl/update_cycle_ctrl.sv
module update_cycle_ctrl
  import ucc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int HOLD_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] div_sel,
  input  logic       set_stop,
  input  logic       regfile_wr,
  output logic       upd_start,
  output logic       upd_end,
  output logic       uip
);

  localparam int CW = $clog2(TICKS_PER_SEC);

  div_mode_e     mode;
  logic          running;
  logic [CW-1:0] phase;

  ucc_div_decode u_decode (
    .div_sel (div_sel),
    .mode    (mode),
    .running (running)
  );

  ucc_phase_counter #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .CW            (CW)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .set_stop (set_stop),
    .phase    (phase)
  );

  ucc_window_gen #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .HOLD_TICKS    (HOLD_TICKS),
    .CW            (CW)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .set_stop   (set_stop),
    .regfile_wr (regfile_wr),
    .phase      (phase),
    .uip        (uip),
    .upd_start  (upd_start),
    .upd_end    (upd_end)
  );

  AST_HELD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel[2:1] == 2'b11) |=> (!upd_end && !upd_start)); // R2
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_start && upd_end)); // R4

endmodule

// File: tb/update_cycle_ctrl_bench.sv
module update_cycle_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 64;
  localparam int HOLD       = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] div_sel;
  logic       set_stop;
  logic       regfile_wr;
  logic       upd_start, upd_end, uip;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  update_cycle_ctrl #(
    .TICKS_PER_SEC (TPS),
    .HOLD_TICKS    (HOLD)
  ) u_update_cycle_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_sel    (div_sel),
    .set_stop   (set_stop),
    .regfile_wr (regfile_wr),
    .upd_start  (upd_start),
    .upd_end    (upd_end),
    .uip        (uip)
  );

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {uip,start,end} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Steps n cycles; the next advance is expected after edge first_end.
  task automatic scan(input int n, input int first_end, input bit wr_toggle, input string tag);
    for (int k = 1; k <= n; k++) begin
      logic eu, es, ee;
      int d, m;
      @(posedge clk);
      @(negedge clk);
      d = k - first_end;
      if (d < 0) begin
        eu = (d >= -HOLD);
        es = (d == -HOLD);
        ee = 1'b0;
      end else begin
        m  = d % TPS;
        eu = (m >= TPS - HOLD);
        es = (m == TPS - HOLD);
        ee = (m == 0);
      end
      check3(tag, {uip, upd_start, upd_end}, {eu, es, ee});
      regfile_wr = wr_toggle ? ~regfile_wr : 1'b0;
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      check3(tag, {uip, upd_start, upd_end}, 3'b000);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; div_sel = 3'b010; set_stop = 1'b0; regfile_wr = 1'b0;
    repeat (3) @(negedge clk);
    check3("R1 during reset", {uip, upd_start, upd_end}, 3'b000);
    rst_n = 1'b1;
    scan(40, TPS / 2, 1'b0, "R1 R3 after reset");
  endtask

  task automatic t_hold_release;
    div_sel = 3'b111;
    quiet(20, "R2 held by 111");
    div_sel = 3'b010;
    scan(140, TPS / 2, 1'b0, "R3 R4 R5 R6 release");
  endtask

  task automatic t_set_stop;
    set_stop = 1'b1;
    quiet(30, "R7 set active");
    set_stop = 1'b0;
    scan(70, TPS, 1'b0, "R7 after set");
  endtask

  task automatic t_halt_resume;
    div_sel = 3'b110;
    quiet(5, "R2 held by 110");
    div_sel = 3'b010;
    scan(10, TPS / 2, 1'b0, "R3 partial run");
    div_sel = 3'b000;
    quiet(25, "R8 frozen");
    div_sel = 3'b010;
    scan(100, TPS / 2 - 10, 1'b0, "R8 resume");
  endtask

  task automatic t_write_in_window;
    // After resume: ends at 22 and 86 of 100 edges, so the next is 50 ahead.
    scan(120, 50, 1'b1, "R9 writes toggling");
    regfile_wr = 1'b0;
  endtask

  initial begin
    t_reset();
    t_hold_release();
    t_set_stop();
    t_halt_resume();
    t_write_in_window();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule